// File: doc/BRIEF.md
# Interleaved I/Q Parallel Port Capture

This block sits at the input of a digital upconverter. It takes one data word per rising edge of the port clock from a parallel bus and routes each word to an in-phase (I) path or a quadrature (Q) path. It has two modes.

- **Quadrature mode:** words alternate I then Q, and each I/Q pair is handed on as one sample.
- **Interpolating mode:** every word feeds the I path and the Q path stays at zero.

A transmit-enable input sets the alignment of the pairing. The first word accepted after enable is always an I word. While enable is low the block flushes zeros down both paths. Optionally, the port can be qualified by a PLL-lock indicator. When the qualify bit is set and lock is absent, the port behaves as if disabled.

The outputs are registered I and Q sample buses with a sample-valid strobe. If enable falls between the I and Q halves of a pair, that half-pair is discarded and a sticky pairing-error flag is raised. Only reset clears the flag.

Top module: `iq_port_capture`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its state after that edge. `i_smp`, `q_smp`, `smp_vld` and `odd_err` read 0, and the next accepted word is treated as an I word.
- R2: Words on `din` are sampled only at the rising clock edge, one per edge. Any output change caused by a word is visible after the edge that sampled it.
- R3: In quadrature mode (`mode_interp`=0), accepted words alternate I, Q, I, Q. At the edge that samples the Q word, `i_smp` takes the preceding I word, `q_smp` takes the Q word, and `smp_vld` is 1 for that cycle. At the edge that samples an I word, `smp_vld` goes to 0 and `i_smp`/`q_smp` hold their values.
- R4: At an edge where the port is disabled (`tx_en`=0), `din` is ignored. `i_smp` and `q_smp` become 0 and `smp_vld` becomes 1, so one zero sample is emitted per cycle.
- R5: In interpolating mode (`mode_interp`=1), every enabled edge loads `din` into `i_smp`, sets `q_smp` to 0 and asserts `smp_vld`. Interpolating mode also resets the pairing so the next quadrature word is an I word.
- R6: When `lock_qual`=1 and `pll_locked`=0, the port acts exactly as disabled, as in R4, even with `tx_en`=1. When `lock_qual`=0, `pll_locked` has no effect.
- R7: If the port becomes disabled after an I word and before its Q word, that I word is never output. Instead, `odd_err` goes to 1 and stays 1 until reset.
- R8: After any disabled cycle, the first word accepted in quadrature mode is an I word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; all capture happens on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_interp | input | 1 | 1 selects interpolating mode, 0 selects quadrature mode |
| lock_qual | input | 1 | 1 qualifies the port with `pll_locked` |
| pll_locked | input | 1 | PLL lock indicator |
| tx_en | input | 1 | Transmit enable; low flushes zeros and realigns the pairing |
| din | input | DATA_W | Parallel data word |
| i_smp | output | DATA_W | I sample |
| q_smp | output | DATA_W | Q sample |
| smp_vld | output | 1 | Sample-valid strobe |
| odd_err | output | 1 | Sticky flag for an unpaired I word |

## Verification
The bench runs these stimulus patterns:

- **Even-length enable bursts** of distinct words, including all-ones and sign-bit patterns. These show whether I and Q are swapped or taken from the wrong edge.
- **Odd-length bursts.** These separate a design that discards the half-pair and raises the error flag from one that leaks the lone I word or keeps a stale phase into the next burst.
- **Enable high with the lock qualifier set and lock absent,** then the same with the qualifier clear. This checks that gating follows the configuration bit rather than lock alone.
- **An interpolating-mode run followed by a return to quadrature mode.** This checks that Q stays zero and that the pairing restarts on an I word.

// File: rtl/iq_cap_pkg.sv
package iq_cap_pkg;
   typedef enum logic {
      PH_EXPECT_I = 1'b0,
      PH_EXPECT_Q = 1'b1
   } iq_phase_e;
endpackage

// File: rtl/iq_cap_gate.sv
module iq_cap_gate #(
   parameter bit LOCK_GATE_EN = 1'b1
) (
   input  logic tx_en,
   input  logic lock_qual,
   input  logic pll_locked,
   output logic port_en
);
   generate
      if (LOCK_GATE_EN) begin : g_lock_gate
         always_comb port_en = tx_en && !(lock_qual && !pll_locked);
      end else begin : g_no_gate
         logic unused_lock;
         always_comb unused_lock = lock_qual ^ pll_locked;
         always_comb port_en = tx_en;
      end
   endgenerate
endmodule

// File: rtl/iq_cap_phase.sv
module iq_cap_phase
   import iq_cap_pkg::*;
#(
   parameter int DATA_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              mode_interp,
   input  logic [DATA_W-1:0] din,
   output logic              take_pair,
   output logic              take_interp,
   output logic [DATA_W-1:0] held_i,
   output logic              odd_err
);
   iq_phase_e phase_q;

   always_comb begin
      take_pair   = port_en && !mode_interp && (phase_q == PH_EXPECT_Q);
      take_interp = port_en && mode_interp;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_EXPECT_I;
         held_i  <= '0;
         odd_err <= 1'b0;
      end else if (!port_en) begin
         if (phase_q == PH_EXPECT_Q) odd_err <= 1'b1;
         phase_q <= PH_EXPECT_I;
      end else if (mode_interp) begin
         phase_q <= PH_EXPECT_I;
      end else if (phase_q == PH_EXPECT_I) begin
         held_i  <= din;
         phase_q <= PH_EXPECT_Q;
      end else begin
         phase_q <= PH_EXPECT_I;
      end
   end

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      odd_err |=> odd_err);
   assert_realign_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> (phase_q == PH_EXPECT_I));
   assert_pair_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && !mode_interp && phase_q == PH_EXPECT_I) |=> (phase_q == PH_EXPECT_Q));
endmodule

// File: rtl/iq_cap_out.sv
module iq_cap_out #(
   parameter int DATA_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              take_pair,
   input  logic              take_interp,
   input  logic [DATA_W-1:0] held_i,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] i_smp,
   output logic [DATA_W-1:0] q_smp,
   output logic              smp_vld
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         i_smp   <= '0;
         q_smp   <= '0;
         smp_vld <= 1'b0;
      end else if (!port_en) begin
         i_smp   <= '0;
         q_smp   <= '0;
         smp_vld <= 1'b1;
      end else if (take_interp) begin
         i_smp   <= din;
         q_smp   <= '0;
         smp_vld <= 1'b1;
      end else if (take_pair) begin
         i_smp   <= held_i;
         q_smp   <= din;
         smp_vld <= 1'b1;
      end else begin
         smp_vld <= 1'b0;
      end
   end

   assert_flush_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> (smp_vld && i_smp == '0 && q_smp == '0));
   assert_pair_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take_pair |=> (smp_vld && q_smp == $past(din) && i_smp == $past(held_i)));
   assert_interp_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
      take_interp |=> (smp_vld && q_smp == '0 && i_smp == $past(din)));
endmodule

// File: rtl/iq_port_capture.sv
module iq_port_capture #(
   parameter int DATA_W       = 14,
   parameter bit LOCK_GATE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_interp,
   input  logic              lock_qual,
   input  logic              pll_locked,
   input  logic              tx_en,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] i_smp,
   output logic [DATA_W-1:0] q_smp,
   output logic              smp_vld,
   output logic              odd_err
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("iq_port_capture: DATA_W must be at least 2");
      end
   endgenerate

   logic              port_en;
   logic              take_pair;
   logic              take_interp;
   logic [DATA_W-1:0] held_i;

   iq_cap_gate #(.LOCK_GATE_EN(LOCK_GATE_EN)) gate_i (
      .tx_en      (tx_en),
      .lock_qual  (lock_qual),
      .pll_locked (pll_locked),
      .port_en    (port_en)
   );

   iq_cap_phase #(.DATA_W(DATA_W)) phase_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .port_en     (port_en),
      .mode_interp (mode_interp),
      .din         (din),
      .take_pair   (take_pair),
      .take_interp (take_interp),
      .held_i      (held_i),
      .odd_err     (odd_err)
   );

   iq_cap_out #(.DATA_W(DATA_W)) out_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .port_en     (port_en),
      .take_pair   (take_pair),
      .take_interp (take_interp),
      .held_i      (held_i),
      .din         (din),
      .i_smp       (i_smp),
      .q_smp       (q_smp),
      .smp_vld     (smp_vld)
   );

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (!smp_vld && !odd_err && i_smp == '0 && q_smp == '0));
   assert_lock_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (LOCK_GATE_EN && lock_qual && !pll_locked) |=> (smp_vld && i_smp == '0 && q_smp == '0));
endmodule

// File: tb/iq_port_capture_tb_top.sv
`timescale 1ns/100ps
module iq_port_capture_tb_top;
   localparam int W = 14;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         mode_interp, lock_qual, pll_locked, tx_en;
   logic [W-1:0] din;
   logic [W-1:0] i_smp, q_smp;
   logic         smp_vld, odd_err;

   int total = 0;
   int bad   = 0;

   // reference model state
   int         m_phase;
   logic [W-1:0] m_hold, m_i, m_q;
   logic       m_v, m_err;

   always #2.5 clk = ~clk;

   iq_port_capture #(.DATA_W(W), .LOCK_GATE_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_interp(mode_interp), .lock_qual(lock_qual),
      .pll_locked(pll_locked), .tx_en(tx_en), .din(din),
      .i_smp(i_smp), .q_smp(q_smp), .smp_vld(smp_vld), .odd_err(odd_err)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, model at posedge, compare just after it
   task automatic step(input string tag, input logic rs, input logic te, input logic mi,
                       input logic lq, input logic lk, input logic [W-1:0] d);
      logic en;
      @(negedge clk);
      rst_n = rs; tx_en = te; mode_interp = mi; lock_qual = lq; pll_locked = lk; din = d;
      @(posedge clk);
      en = te && !(lq && !lk);
      if (!rs) begin
         m_phase = 0; m_hold = '0; m_i = '0; m_q = '0; m_v = 1'b0; m_err = 1'b0;
      end else if (!en) begin
         if (m_phase == 1) m_err = 1'b1;
         m_phase = 0; m_i = '0; m_q = '0; m_v = 1'b1;
      end else if (mi) begin
         m_phase = 0; m_i = d; m_q = '0; m_v = 1'b1;
      end else if (m_phase == 0) begin
         m_hold = d; m_phase = 1; m_v = 1'b0;
      end else begin
         m_i = m_hold; m_q = d; m_v = 1'b1; m_phase = 0;
      end
      #1;
      chk(tag, "i_smp", int'(i_smp), int'(m_i));
      chk(tag, "q_smp", int'(q_smp), int'(m_q));
      chk(tag, "smp_vld", int'(smp_vld), int'(m_v));
      chk(tag, "odd_err", int'(odd_err), int'(m_err));
   endtask

   initial begin
      #1_000_000;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; tx_en = 1'b0; mode_interp = 1'b0; lock_qual = 1'b0;
      pll_locked = 1'b0; din = '0;
      m_phase = 0; m_hold = '0; m_i = '0; m_q = '0; m_v = 1'b0; m_err = 1'b0;
      // R1 reset state
      for (int k = 0; k < 3; k++) step("R1", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 14'h1abc);
      // R4 disabled: data ignored, zero samples flow
      for (int k = 0; k < 4; k++) step("R4", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 14'h3000 + 14'(k));
      // R3 / R2 quadrature pairs
      step("R3", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0064);
      step("R3", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 14'h00c8);
      step("R3", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 14'h3fff);
      step("R3", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 14'h2000);
      for (int k = 0; k < 6; k++) step("R2", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 14'(k * 14'h0531 + 7));
      step("R4", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 14'h1555);
      // R7 odd burst: lone I discarded, error sticky
      step("R7", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0aaa);
      step("R7", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0bbb);
      step("R7", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0ccc);
      // R8 realign after disable
      step("R8", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0111);
      step("R8", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0222);
      step("R7", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0333);
      // R6 lock qualification mid-pair: acts as disable
      step("R6", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 14'h0444);
      step("R6", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 14'h0555);
      step("R6", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 14'h0666);
      step("R6", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 14'h0777);
      step("R6", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0888);
      step("R6", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0999);
      // R5 interpolating mode, then back to quadrature mid-phase
      step("R5", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 14'h1234);
      for (int k = 0; k < 5; k++) step("R5", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 14'h2100 + 14'(k * 3));
      step("R5", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0f0f);
      step("R5", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 14'h30f0);
      // R1 reset clears the sticky flag
      step("R1", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0001);
      step("R1", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0002);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule